// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the device side of a three-wire serial link that lets an external host reach a bank of timekeeping registers and a small scratch RAM. The host raises a select line, toggles a serial clock and moves data over one shared data line. The block resynchronises all three wires into the system clock domain. It decodes a leading command byte and turns each completed data byte into a single-cycle parallel strobe toward the register bank. The register bank itself lies outside the block.

A command byte names the target space (clock/calendar or RAM), an index inside that space and the direction. An index field of all ones starts a burst: consecutive indices are moved from index 0, eight for the clock space and thirty-one for the RAM. On reads the block takes over the data line after the command and shifts the bank's bytes out. A lock flag supplied by the bank blocks every write except writes to the control register.

Top module: `tw_reg_port`

## Requirements
- R1: After reset, and while select is low, `ser_doe` is 0 and neither `bank_wr` nor `bank_rd` pulses.
- R2: Bits are sampled on rising serial-clock edges, least significant bit first. In the command byte, bit 6 picks the space (0 clock, 1 RAM), bits 5..1 give the index and bit 0 the direction (0 write, 1 read). A single write produces exactly one `bank_wr` pulse carrying that space, that index and the following data byte.
- R3: A command whose bit 7 is 0 produces no `bank_wr` pulse and never drives the data line, whatever follows it.
- R4: On a single read, `ser_doe` stays 0 through the eighth command bit. From the next falling serial-clock edge the byte is driven LSB first, one bit per falling edge. The line is released at the falling edge after the eighth data bit.
- R5: While `wr_lock` is 1, writes are dropped except to clock-space index 7 (the control register). A write of 0 there re-enables writes.
- R6: A clock-space write with index 31 stores bytes into indices 0 through 7 in order. Bytes beyond the eighth produce no pulse.
- R7: A RAM-space write with index 31 stores bytes into indices 0 through 30 in order. Bytes beyond the thirty-first produce no pulse.
- R8: A burst read returns the bytes at indices 0 upward of the selected space (8 for clock, 31 for RAM), each LSB first. The line is released after the last one.
- R9: Dropping select aborts the transfer: the data line is released, any partial byte is discarded and the next transfer starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | Transfer select from the host, high during a transfer |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Data line value seen at the pad |
| ser_dout | output | 1 | Data value driven toward the pad on reads |
| ser_doe | output | 1 | Pad output enable for the data line |
| wr_lock | input | 1 | Write lock flag from the control register |
| bank_space | output | 1 | Target space: 0 clock registers, 1 RAM |
| bank_index | output | 5 | Register or RAM index |
| bank_wr | output | 1 | One-cycle write strobe |
| bank_wdata | output | 8 | Write data, valid with `bank_wr` |
| bank_rd | output | 1 | One-cycle read fetch strobe |
| bank_rdata | input | 8 | Read data returned by the bank in the same cycle |

## Verification
A wrong bit counter or shift register shows as a wrong `bank_wdata` or index on the very next write strobe, or as a corrupted bit in the next read byte. A stuck burst counter shows up one byte past the burst limit as an extra strobe or a line that is never released. A stale state after select drops shows on the following transfer as a missing or misplaced strobe. A lock decision that goes wrong shows as a write strobe to a protected index, or as a missing control write, in the same transfer.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int CMD_W = 8;
  localparam int IDX_W = 5;
  localparam logic [IDX_W-1:0] BURST_CODE = '1;

  typedef struct packed {
    logic             valid;
    logic             ram;
    logic [IDX_W-1:0] index;
    logic             read;
  } cmd_t;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_DONE} xfer_st_t;

  // Split a command byte into its fields.
  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] b);
    cmd_t c;
    c.valid = b[7];
    c.ram   = b[6];
    c.index = b[5:1];
    c.read  = b[0];
    return c;
  endfunction

  // Number of bytes a transfer may move.
  function automatic int unsigned xfer_limit(input logic burst, input logic ram,
                                             input int unsigned clk_n,
                                             input int unsigned ram_n);
    if (!burst) return 1;
    return ram ? ram_n : clk_n;
  endfunction

  // Lock rule: only the control register stays writable.
  function automatic logic write_ok(input logic lock, input logic ram,
                                    input logic [IDX_W-1:0] idx,
                                    input int unsigned ctrl);
    return !lock || (!ram && idx == IDX_W'(ctrl));
  endfunction
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sel_in,
  input  logic din_in,
  output logic sel_q,
  output logic din_q,
  output logic sck_rise,
  output logic sck_fall
);
  logic [STAGES-1:0] sck_p, sel_p, din_p;
  logic sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sel_p <= '0;
      din_p <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_p <= {sck_p[STAGES-2:0], sck_in};
      sel_p <= {sel_p[STAGES-2:0], sel_in};
      din_p <= {din_p[STAGES-2:0], din_in};
      sck_d <= sck_p[STAGES-1];
    end
  end

  assign sel_q    = sel_p[STAGES-1];
  assign din_q    = din_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;

  assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall));
endmodule

// File: rtl/tw_rx_shift.sv
module tw_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         din,
  output logic         byte_done,
  output logic [W-1:0] byte_val
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift_en) begin
      sh  <= {din, sh[W-1:1]};
      cnt <= cnt + 1'b1;
    end
  end

  // LSB arrives first, so the newest bit is the MSB.
  assign byte_done = shift_en && (cnt == CW'(W-1));
  assign byte_val  = {din, sh[W-1:1]};

  assert_clear_restarts_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !byte_done);
endmodule

// File: rtl/tw_tx_shift.sv
module tw_tx_shift #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 load,
  input  logic                 adv,
  input  logic                 release_line,
  input  logic [W-1:0]         din,
  output logic                 dout,
  output logic                 oe,
  output logic [$clog2(W)-1:0] pos
);
  localparam int CW = $clog2(W);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      pos  <= '0;
      dout <= 1'b0;
      oe   <= 1'b0;
    end else if (clear) begin
      pos <= '0;
      oe  <= 1'b0;
    end else if (load) begin
      dout <= din[0];
      sh   <= {1'b0, din[W-1:1]};
      pos  <= CW'(1);
      oe   <= 1'b1;
    end else if (adv) begin
      dout <= sh[0];
      sh   <= {1'b0, sh[W-1:1]};
      pos  <= pos + 1'b1;
    end else if (release_line) begin
      oe <= 1'b0;
    end
  end

  assert_load_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> pos == '0);
endmodule

// File: rtl/tw_reg_port.sv
module tw_reg_port #(
  parameter int CLK_BYTES   = 8,
  parameter int RAM_BYTES   = 31,
  parameter int CTRL_INDEX  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_sel,
  input  logic       ser_clk,
  input  logic       ser_din,
  output logic       ser_dout,
  output logic       ser_doe,
  input  logic       wr_lock,
  output logic       bank_space,
  output logic [4:0] bank_index,
  output logic       bank_wr,
  output logic [7:0] bank_wdata,
  output logic       bank_rd,
  input  logic [7:0] bank_rdata
);
  import tw_pkg::*;

  localparam int MAXB = (CLK_BYTES > RAM_BYTES) ? CLK_BYTES : RAM_BYTES;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int PW = $clog2(CMD_W);

  logic sel_q, din_q, sck_rise, sck_fall;
  logic rx_done;
  logic [CMD_W-1:0] rx_byte;
  logic [PW-1:0] tx_pos;

  xfer_st_t st;
  logic space_r, burst_r;
  logic [IDX_W-1:0] idx_r;
  logic [CNT_W-1:0] cnt_r, limit;

  // Named internal events
  logic rx_en, cmd_done, data_done, wr_fire;
  logic rd_edge, rd_fetch, rd_stop, tx_adv, more;
  cmd_t cmd;

  tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(ser_clk), .sel_in(ser_sel), .din_in(ser_din),
    .sel_q(sel_q), .din_q(din_q), .sck_rise(sck_rise), .sck_fall(sck_fall));

  assign rx_en = sel_q && sck_rise && (st == ST_CMD || st == ST_WR);

  tw_rx_shift #(.W(CMD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(!sel_q), .shift_en(rx_en), .din(din_q),
    .byte_done(rx_done), .byte_val(rx_byte));

  assign cmd       = decode_cmd(rx_byte);
  assign limit     = CNT_W'(xfer_limit(burst_r, space_r, CLK_BYTES, RAM_BYTES));
  assign more      = cnt_r < limit;
  assign cmd_done  = rx_done && st == ST_CMD;
  assign data_done = rx_done && st == ST_WR;
  assign wr_fire   = data_done && write_ok(wr_lock, space_r, idx_r, CTRL_INDEX);
  assign rd_edge   = sel_q && sck_fall && st == ST_RD;
  assign rd_fetch  = rd_edge && tx_pos == '0 && more;
  assign rd_stop   = rd_edge && tx_pos == '0 && !more;
  assign tx_adv    = rd_edge && tx_pos != '0;

  tw_tx_shift #(.W(CMD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(!sel_q), .load(rd_fetch), .adv(tx_adv),
    .release_line(rd_stop), .din(bank_rdata), .dout(ser_dout), .oe(ser_doe),
    .pos(tx_pos));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_CMD;
      space_r <= 1'b0;
      burst_r <= 1'b0;
      idx_r   <= '0;
      cnt_r   <= '0;
    end else if (!sel_q) begin
      st    <= ST_CMD;
      cnt_r <= '0;
    end else if (cmd_done) begin
      if (!cmd.valid) begin
        st <= ST_DONE;
      end else begin
        space_r <= cmd.ram;
        burst_r <= (cmd.index == BURST_CODE);
        idx_r   <= (cmd.index == BURST_CODE) ? '0 : cmd.index;
        cnt_r   <= '0;
        st      <= cmd.read ? ST_RD : ST_WR;
      end
    end else if (data_done) begin
      idx_r <= idx_r + 1'b1;
      cnt_r <= cnt_r + 1'b1;
      if (cnt_r + 1'b1 == limit) st <= ST_DONE;
    end else if (rd_fetch) begin
      idx_r <= idx_r + 1'b1;
      cnt_r <= cnt_r + 1'b1;
    end else if (rd_stop) begin
      st <= ST_DONE;
    end
  end

  assign bank_space = space_r;
  assign bank_index = idx_r;
  assign bank_wr    = wr_fire;
  assign bank_wdata = rx_byte;
  assign bank_rd    = rd_fetch;

  assert_released_when_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> !ser_doe);
  assert_quiet_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> !bank_wr && !bank_rd);
  assert_lock_spares_control_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && wr_lock) |-> (!bank_space && bank_index == IDX_W'(CTRL_INDEX)));
  assert_burst_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_r <= limit);
  assert_drive_follows_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_doe) |-> $past(bank_rd));
  assert_no_strobe_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_wr && bank_rd));
endmodule

// File: tb/tw_reg_port_test.sv
module tw_reg_port_test;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sck = 1'b0, sd = 1'b0;
  logic ser_dout, ser_doe, bank_space, bank_wr, bank_rd;
  logic [4:0] bank_index;
  logic [7:0] bank_wdata, bank_rdata;
  logic [7:0] clkr [8];
  logic [7:0] ramm [31];
  logic wr_lock;
  logic [13:0] exp_q [$];
  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign wr_lock = clkr[7][7];
  assign bank_rdata = bank_space ? ((bank_index < 5'd31) ? ramm[bank_index] : 8'h00)
                                 : ((bank_index < 5'd8) ? clkr[bank_index[2:0]] : 8'h00);

  tw_reg_port uut (
    .clk(clk), .rst_n(rst_n), .ser_sel(sel), .ser_clk(sck), .ser_din(sd),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .wr_lock(wr_lock),
    .bank_space(bank_space), .bank_index(bank_index), .bank_wr(bank_wr),
    .bank_wdata(bank_wdata), .bank_rd(bank_rd), .bank_rdata(bank_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: bank model plus scoreboard of write strobes
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) clkr[i] = 8'h00;
      for (int i = 0; i < 31; i++) ramm[i] = 8'h00;
    end else if (bank_wr) begin
      if (exp_q.size() == 0) begin
        chk("R3/R5 unexpected write", {18'd0, bank_space, bank_index, bank_wdata}, 32'hFFFF);
      end else begin
        chk("R2 write strobe", {18'd0, bank_space, bank_index, bank_wdata},
            {18'd0, exp_q.pop_front()});
      end
      if (bank_space) begin
        if (bank_index < 5'd31) ramm[bank_index] = bank_wdata;
      end else if (bank_index < 5'd8) clkr[bank_index[2:0]] = bank_wdata;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sd = b; wait_clk(HP); sck = 1'b1; wait_clk(HP); sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic recv_bit(output logic b, output logic oe);
    wait_clk(HP); b = ser_dout; oe = ser_doe; sck = 1'b1; wait_clk(HP); sck = 1'b0;
  endtask

  task automatic begin_xfer();
    sck = 1'b0; sel = 1'b1; wait_clk(HP);
  endtask

  task automatic end_xfer();
    wait_clk(HP); sel = 1'b0; wait_clk(2 * HP);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed + 8'(k * 37);
  endfunction

  // Driver: pushes expected strobes, then shifts the transfer out
  task automatic wr_xfer(input string req, input logic valid, input logic ram,
                         input logic [4:0] addr, input int n, input logic [7:0] seed);
    logic burst, lock_now;
    int lim;
    logic [4:0] idx;
    burst = (addr == 5'd31);
    lim = burst ? (ram ? 31 : 8) : 1;
    lock_now = clkr[7][7];
    if (valid) begin
      for (int k = 0; k < n && k < lim; k++) begin
        idx = burst ? 5'(k) : addr;
        if (!lock_now || (!ram && idx == 5'd7)) exp_q.push_back({ram, idx, pat(seed, k)});
        if (!ram && idx == 5'd7) lock_now = pat(seed, k) >> 7;
      end
    end
    begin_xfer();
    send_byte({valid, ram, addr, 1'b0});
    for (int k = 0; k < n; k++) send_byte(pat(seed, k));
    end_xfer();
    chk({req, " pending writes"}, exp_q.size(), 0);
  endtask

  task automatic rd_xfer(input string req, input logic valid, input logic ram,
                         input logic [4:0] addr, input int n);
    logic [7:0] got, exp_b;
    logic b, oe, all_oe, any_oe;
    logic [4:0] idx;
    begin_xfer();
    send_byte({valid, ram, addr, 1'b1});
    chk({req, " line idle during command"}, ser_doe, 0);
    for (int k = 0; k < n; k++) begin
      idx = (addr == 5'd31) ? 5'(k) : addr;
      exp_b = ram ? ramm[idx] : clkr[idx[2:0]];
      all_oe = 1'b1; any_oe = 1'b0;
      for (int i = 0; i < 8; i++) begin
        recv_bit(b, oe);
        got[i] = b; all_oe &= oe; any_oe |= oe;
      end
      if (valid) begin
        chk({req, " read byte"}, got, exp_b);
        chk({req, " line driven"}, all_oe, 1);
      end else begin
        chk({req, " line never driven"}, any_oe, 0);
      end
    end
    wait_clk(HP);
    chk({req, " line released"}, ser_doe, 0);
    end_xfer();
  endtask

  initial begin
    logic b, oe;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1 reset oe", ser_doe, 0);
    chk("R1 reset strobes", {bank_wr, bank_rd}, 0);

    wr_xfer("R2 clock single", 1, 0, 5'd2, 1, 8'h5A);
    wr_xfer("R2 ram single", 1, 1, 5'd5, 1, 8'hC3);
    wr_xfer("R3 invalid write", 0, 1, 5'd6, 1, 8'h77);
    rd_xfer("R3 ram untouched", 1, 1, 5'd6, 1);
    rd_xfer("R3 invalid read", 0, 1, 5'd5, 1);

    rd_xfer("R4 clock single", 1, 0, 5'd2, 1);
    rd_xfer("R4 ram single", 1, 1, 5'd5, 1);

    wr_xfer("R6 clock burst", 1, 0, 5'd31, 10, 8'h10);
    rd_xfer("R8 clock burst", 1, 0, 5'd31, 8);
    wr_xfer("R7 ram burst", 1, 1, 5'd31, 33, 8'h21);
    rd_xfer("R8 ram burst", 1, 1, 5'd31, 31);

    wr_xfer("R5 set lock", 1, 0, 5'd7, 1, 8'h80);
    chk("R5 lock set", wr_lock, 1);
    wr_xfer("R5 locked ram", 1, 1, 5'd3, 1, 8'h11);
    wr_xfer("R5 locked clock", 1, 0, 5'd1, 1, 8'h42);
    rd_xfer("R5 ram kept", 1, 1, 5'd3, 1);
    wr_xfer("R5 clear lock", 1, 0, 5'd7, 1, 8'h00);
    chk("R5 lock cleared", wr_lock, 0);
    wr_xfer("R5 unlocked ram", 1, 1, 5'd3, 1, 8'h22);

    // R9: abort inside a command, then a clean transfer
    begin_xfer();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    end_xfer();
    wr_xfer("R9 after abort", 1, 1, 5'd9, 1, 8'h9C);
    rd_xfer("R9 value stored", 1, 1, 5'd9, 1);
    // R9: abort during a read releases the line
    begin_xfer();
    send_byte({1'b1, 1'b1, 5'd9, 1'b1});
    for (int i = 0; i < 3; i++) recv_bit(b, oe);
    chk("R9 driving before abort", oe, 1);
    sel = 1'b0;
    wait_clk(6);
    chk("R9 released on abort", ser_doe, 0);
    wait_clk(2 * HP);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule